// File: doc/BRIEF.md
# Shared-Pin Port Multiplexer

This block manages eight bidirectional pins that can either act as general-purpose I/O or be lent to an on-chip SPI-style controller and a UART transmitter. Software controls it through three byte-wide registers in two 16-bit words. The first word holds the output latch. The second word holds a per-pin direction byte in its lower half and a per-pin assignment byte in its upper half. A read of the first word returns the live pin levels, not the latched value.

Six of the pins are handed to the SPI function one at a time by their assignment bits. The other two pins have no assignment bit. One becomes the serial clock whenever the SPI enable flag is set. The other becomes the UART transmit line whenever the transmitter enable flag is set. When a pin belongs to a peripheral, its drive value and its output enable come from that peripheral. Data-line and clock directions follow the SPI master/slave input. Software should load the output latch before it turns pins into outputs, so that no undefined value reaches a pin.

Top module: `qspin_port`

## Requirements
- R1: After reset the output latch, direction byte and assignment byte are all zero, and every pin_oe bit is 0.
- R2: A write to word 0 (acc_addr=0) with acc_be[0]=1 loads acc_wdata[7:0] into the output latch on the next clock edge. acc_be[1] alone changes nothing. A general-purpose pin i drives latch bit i on pin_out[i].
- R3: Reading word 0 returns pin_in in bits 7..0 and zero in bits 15..8.
- R4: For a general-purpose pin i, pin_oe[i] equals direction bit i (1 = output, 0 = input).
- R5: In word 1 the direction byte (bits 7..0) is written only when acc_be[0]=1 and the assignment byte (bits 15..8) only when acc_be[1]=1. Each byte keeps its value when only the other byte is written. A read of word 1 returns {assignment, direction}.
- R6: Assignment bits 2 and 7 (word 1 bits 10 and 15) always read 0 and ignore writes. Bits 0, 1, 3, 4, 5 and 6 are stored as written.
- R7: A pin whose assignment bit is 1 carries the peripheral value: pin 0 = MISO drive, pin 1 = MOSI drive, pin 3 = chip select 0, pins 4, 5 and 6 = chip selects 1, 2 and 3.
- R8: On peripheral pins the enables follow spi_master. Pin 0 is enabled when spi_master=0. Pins 1 and 3 are enabled when spi_master=1. Pins 4 to 6 are always enabled.
- R9: While spi_en=1, pin 2 carries spi_sck_drv with pin_oe[2]=spi_master, whatever the registers hold. While spi_en=0, pin 2 is general-purpose.
- R10: While uart_te=1, pin 7 drives uart_txd with pin_oe[7]=1. While uart_te=0, pin 7 is general-purpose. The assignment byte never affects pin 7.
- R11: spi_miso_rcv, spi_mosi_rcv, spi_sck_rcv and spi_ss_rcv follow pin_in bits 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | Word select: 0 = latch/levels, 1 = assignment/direction |
| acc_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for the selected word |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Values driven to the pads |
| pin_oe | output | 8 | Pad output enables |
| spi_en | input | 1 | SPI enable flag; claims pin 2 |
| spi_master | input | 1 | 1 = SPI master, 0 = slave |
| spi_miso_drv | input | 1 | MISO value from the SPI |
| spi_mosi_drv | input | 1 | MOSI value from the SPI |
| spi_sck_drv | input | 1 | Serial clock from the SPI |
| spi_cs_drv | input | 4 | Chip selects 0..3 from the SPI |
| spi_miso_rcv | output | 1 | Level of pin 0 to the SPI |
| spi_mosi_rcv | output | 1 | Level of pin 1 to the SPI |
| spi_sck_rcv | output | 1 | Level of pin 2 to the SPI |
| spi_ss_rcv | output | 1 | Level of pin 3 to the SPI |
| uart_te | input | 1 | UART transmitter enable; claims pin 7 |
| uart_txd | input | 1 | UART serial output |

## Verification
The bench targets the two pins without assignment bits. It sets their assignment bits while both enable flags are clear, and clears them while the flags are set. A design that decoded those bits would move pin 2 or pin 7 to the wrong owner, or would read back a nonzero bit 10 or 15. Byte-enable writes of word 1 are split so that a design which clobbers the untouched byte shows a changed direction or assignment. Word 0 reads are taken with pin_in different from the latch, which exposes a design that returns the latch. The SPI master and slave settings are swept on every peripheral pin to catch an inverted or swapped data-line enable.

// File: rtl/qspin_pkg.sv
package qspin_pkg;
  localparam int NPIN    = 8;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int NCS     = 4;
  localparam logic ADDR_LATCH = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;
  // pin roles; positions matter because the mux decodes them
  localparam int PIN_MISO = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_CS0  = 3;
  localparam int PIN_CS3  = 6;
  localparam int PIN_TXD  = 7;
  // assignment bits that physically exist
  localparam logic [BYTE_W-1:0] ASG_IMPL = 8'b0111_1011;
endpackage

// File: rtl/qspin_rstsync.sv
module qspin_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/qspin_regs.sv
module qspin_regs
  import qspin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_addr,
  input  logic [1:0]        acc_be,
  input  logic [WORD_W-1:0] acc_wdata,
  input  logic [NPIN-1:0]   pin_lvl,
  output logic [NPIN-1:0]   data_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   asg_q,
  output logic [WORD_W-1:0] acc_rdata
);
  logic wr_latch, wr_dir, wr_asg;
  logic [NPIN-1:0] data_d, dir_d, asg_d;

  assign wr_latch = acc_en && acc_wr && (acc_addr == ADDR_LATCH) && acc_be[0];
  assign wr_dir   = acc_en && acc_wr && (acc_addr == ADDR_CTRL)  && acc_be[0];
  assign wr_asg   = acc_en && acc_wr && (acc_addr == ADDR_CTRL)  && acc_be[1];

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    asg_d  = asg_q;
    if (wr_latch) data_d = acc_wdata[BYTE_W-1:0];
    if (wr_dir)   dir_d  = acc_wdata[BYTE_W-1:0];
    if (wr_asg)   asg_d  = acc_wdata[WORD_W-1:BYTE_W] & ASG_IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      asg_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
      asg_q  <= asg_d;
    end
  end

  always_comb begin
    if (acc_addr == ADDR_LATCH) acc_rdata = {{BYTE_W{1'b0}}, pin_lvl};
    else                        acc_rdata = {asg_q, dir_q};
  end

  // R2: a low-byte latch write lands on the next edge
  p_latch_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> data_q == $past(acc_wdata[BYTE_W-1:0]));

  // R5: direction byte holds unless its own byte is written
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));

  // R6: unimplemented assignment bits read zero
  p_asg_hole_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == ADDR_CTRL) |-> (acc_rdata[BYTE_W+PIN_SCK] == 1'b0 &&
                                 acc_rdata[BYTE_W+PIN_TXD] == 1'b0));
endmodule

// File: rtl/qspin_pinmux.sv
module qspin_pinmux
  import qspin_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] data_q,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] asg_q,
  input  logic            spi_en,
  input  logic            spi_master,
  input  logic            spi_miso_drv,
  input  logic            spi_mosi_drv,
  input  logic            spi_sck_drv,
  input  logic [NCS-1:0]  spi_cs_drv,
  input  logic            uart_te,
  input  logic            uart_txd,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  logic [NPIN-1:0] take, per_out, per_oe;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i == PIN_SCK) begin : g_own_sck
      assign take[i] = spi_en;
    end else if (i == PIN_TXD) begin : g_own_txd
      assign take[i] = uart_te;
    end else begin : g_own_asg
      assign take[i] = asg_q[i];
    end

    if (i == PIN_MISO) begin : g_miso
      assign per_out[i] = spi_miso_drv;
      assign per_oe[i]  = ~spi_master;
    end else if (i == PIN_MOSI) begin : g_mosi
      assign per_out[i] = spi_mosi_drv;
      assign per_oe[i]  = spi_master;
    end else if (i == PIN_SCK) begin : g_sck
      assign per_out[i] = spi_sck_drv;
      assign per_oe[i]  = spi_master;
    end else if (i == PIN_CS0) begin : g_cs0
      assign per_out[i] = spi_cs_drv[0];
      assign per_oe[i]  = spi_master;
    end else if (i > PIN_CS0 && i <= PIN_CS3) begin : g_csn
      assign per_out[i] = spi_cs_drv[i-PIN_CS0];
      assign per_oe[i]  = 1'b1;
    end else begin : g_txd
      assign per_out[i] = uart_txd;
      assign per_oe[i]  = 1'b1;
    end

    assign pin_out[i] = take[i] ? per_out[i] : data_q[i];
    assign pin_oe[i]  = take[i] ? per_oe[i]  : dir_q[i];
  end

  // R9: serial clock takeover by enable flag
  p_sck_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> (pin_out[PIN_SCK] == spi_sck_drv && pin_oe[PIN_SCK] == spi_master));

  // R10: transmit line takeover ignores assignment byte
  p_txd_own_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uart_te |-> (pin_out[PIN_TXD] == uart_txd && pin_oe[PIN_TXD]));

  // R4: unassigned chip-select pin behaves as plain I/O
  p_gpio_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !asg_q[PIN_CS0+1] |-> (pin_oe[PIN_CS0+1] == dir_q[PIN_CS0+1] &&
                           pin_out[PIN_CS0+1] == data_q[PIN_CS0+1]));

  // R8: MISO and MOSI never drive together while both are lent
  p_data_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_q[PIN_MISO] && asg_q[PIN_MOSI]) |-> $onehot(pin_oe[PIN_MOSI:PIN_MISO]));
endmodule

// File: rtl/qspin_port.sv
module qspin_port
  import qspin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_addr,
  input  logic [1:0]        acc_be,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic [WORD_W-1:0] acc_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic              spi_miso_drv,
  input  logic              spi_mosi_drv,
  input  logic              spi_sck_drv,
  input  logic [NCS-1:0]    spi_cs_drv,
  output logic              spi_miso_rcv,
  output logic              spi_mosi_rcv,
  output logic              spi_sck_rcv,
  output logic              spi_ss_rcv,
  input  logic              uart_te,
  input  logic              uart_txd
);
  logic            rst_sync_n;
  logic [NPIN-1:0] data_q, dir_q, asg_q;

  qspin_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  qspin_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .pin_lvl(pin_in),
    .data_q(data_q), .dir_q(dir_q), .asg_q(asg_q), .acc_rdata(acc_rdata)
  );

  qspin_pinmux u_mux (
    .clk(clk), .rst_n(rst_sync_n),
    .data_q(data_q), .dir_q(dir_q), .asg_q(asg_q),
    .spi_en(spi_en), .spi_master(spi_master),
    .spi_miso_drv(spi_miso_drv), .spi_mosi_drv(spi_mosi_drv),
    .spi_sck_drv(spi_sck_drv), .spi_cs_drv(spi_cs_drv),
    .uart_te(uart_te), .uart_txd(uart_txd),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign spi_miso_rcv = pin_in[PIN_MISO];
  assign spi_mosi_rcv = pin_in[PIN_MOSI];
  assign spi_sck_rcv  = pin_in[PIN_SCK];
  assign spi_ss_rcv   = pin_in[PIN_CS0];
endmodule

// File: tb/qspin_port_tb_top.sv
module qspin_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_wr, acc_addr;
  logic [1:0]  acc_be;
  logic [15:0] acc_wdata, acc_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe;
  logic        spi_en, spi_master, spi_miso_drv, spi_mosi_drv, spi_sck_drv;
  logic [3:0]  spi_cs_drv;
  logic        spi_miso_rcv, spi_mosi_rcv, spi_sck_rcv, spi_ss_rcv;
  logic        uart_te, uart_txd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_data, m_dir, m_asg;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspin_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_be(acc_be),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .spi_en(spi_en), .spi_master(spi_master),
    .spi_miso_drv(spi_miso_drv), .spi_mosi_drv(spi_mosi_drv),
    .spi_sck_drv(spi_sck_drv), .spi_cs_drv(spi_cs_drv),
    .spi_miso_rcv(spi_miso_rcv), .spi_mosi_rcv(spi_mosi_rcv),
    .spi_sck_rcv(spi_sck_rcv), .spi_ss_rcv(spi_ss_rcv),
    .uart_te(uart_te), .uart_txd(uart_txd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [15:0] exp_rd;
    if (acc_addr == 1'b0) begin
      exp_rd = {8'h00, pin_in};
      chk("R3 word0 read", acc_rdata, exp_rd);
    end else begin
      exp_rd = {m_asg, m_dir};
      if (acc_rdata[15] !== 1'b0 || acc_rdata[10] !== 1'b0)
        chk("R6 unimplemented assignment bits", acc_rdata, exp_rd);
      else
        chk("R5 word1 read", acc_rdata, exp_rd);
    end
    for (int i = 0; i < 8; i++) begin
      bit take, e_out, e_oe;
      string tag;
      if (i == 2)      take = spi_en;
      else if (i == 7) take = uart_te;
      else             take = m_asg[i];
      if (!take) begin
        e_out = m_data[i]; e_oe = m_dir[i];
      end else begin
        case (i)
          0: begin e_out = spi_miso_drv;      e_oe = !spi_master; end
          1: begin e_out = spi_mosi_drv;      e_oe = spi_master;  end
          2: begin e_out = spi_sck_drv;       e_oe = spi_master;  end
          3: begin e_out = spi_cs_drv[0];     e_oe = spi_master;  end
          7: begin e_out = uart_txd;          e_oe = 1'b1;        end
          default: begin e_out = spi_cs_drv[i-3]; e_oe = 1'b1;    end
        endcase
      end
      if (i == 7)      tag = take ? "R10 txd pin" : "R10 pin7 gpio";
      else if (i == 2) tag = take ? "R9 sck pin" : "R9 pin2 gpio";
      else if (take)   tag = "R7 peripheral value";
      else             tag = "R2 latch drive";
      chk($sformatf("%s out pin%0d", tag, i), pin_out[i], e_out);
      if (take && i != 2 && i != 7) tag = "R8 peripheral enable";
      else if (!take && i != 2 && i != 7) tag = "R4 direction";
      chk($sformatf("%s oe pin%0d", tag, i), pin_oe[i], e_oe);
    end
    chk("R11 receive lines", {spi_ss_rcv, spi_sck_rcv, spi_mosi_rcv, spi_miso_rcv},
        pin_in[3:0]);
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic cyc();
    @(posedge clk);
    if (acc_en && acc_wr && rst_n) begin
      if (acc_addr == 1'b0 && acc_be[0]) m_data = acc_wdata[7:0];
      if (acc_addr == 1'b1 && acc_be[0]) m_dir  = acc_wdata[7:0];
      if (acc_addr == 1'b1 && acc_be[1]) m_asg  = acc_wdata[15:8] & 8'h7B;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic a, input logic [1:0] be, input logic [15:0] d);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_be = be; acc_wdata = d;
    cyc();
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic a);
    acc_en = 1; acc_wr = 0; acc_addr = a; acc_be = 2'b11;
    cyc();
    acc_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; m_data = 0; m_dir = 0; m_asg = 0;
    acc_en = 0; acc_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; acc_en = 0; acc_wr = 0; acc_addr = 1; acc_be = 0; acc_wdata = 0;
    pin_in = 8'h3C; spi_en = 0; spi_master = 0; spi_miso_drv = 0;
    spi_mosi_drv = 0; spi_sck_drv = 0; spi_cs_drv = 0; uart_te = 0; uart_txd = 0;
    m_data = 0; m_dir = 0; m_asg = 0;
    repeat (2) @(negedge clk);
    chk("R1 oe during reset", pin_oe, 0);
    rst_n = 1;
    repeat (3) cyc();
    // R1: explicit reset view
    chk("R1 oe after reset", pin_oe, 0);
    chk("R1 word1 after reset", acc_rdata, 0);

    // R2: latch then directions; upper byte alone is ignored
    wr(0, 2'b01, 16'hFFA5);
    wr(1, 2'b01, 16'h00FF);
    wr(0, 2'b10, 16'h5A00);
    chk("R2 upper-only write ignored", pin_out, 8'hA5);
    // R3: levels differ from latch
    pin_in = 8'h96; rd(0);
    pin_in = 8'h01; rd(0);
    // R5/R6: upper byte only, then lower only
    wr(1, 2'b10, 16'hFF00);
    rd(1);
    chk("R6 assignment readback", acc_rdata, 16'h7BFF);
    wr(1, 2'b01, 16'hAA0F);
    chk("R5 assignment kept", acc_rdata, 16'h7B0F);
    // R7/R8: peripheral values under both roles
    for (int m = 0; m < 2; m++) begin
      spi_master = m[0];
      spi_miso_drv = 1; spi_mosi_drv = 0; spi_cs_drv = 4'b1010; cyc();
      spi_miso_drv = 0; spi_mosi_drv = 1; spi_cs_drv = 4'b0101; cyc();
    end
    // R9/R10: takeover flags with assignment bits cleared
    wr(1, 2'b10, 16'h0000);
    spi_en = 1; spi_sck_drv = 1; uart_te = 1; uart_txd = 0; cyc();
    chk("R10 txd drives", {pin_oe[7], pin_out[7]}, 2'b10);
    spi_master = 0; uart_txd = 1; cyc();
    spi_en = 0; uart_te = 0; cyc();
    // random sweep
    for (int n = 0; n < 300; n++) begin
      acc_en = $urandom_range(0, 1); acc_wr = $urandom_range(0, 1);
      acc_addr = $urandom_range(0, 1); acc_be = 2'($urandom);
      acc_wdata = 16'($urandom); pin_in = 8'($urandom);
      spi_en = $urandom_range(0, 1); spi_master = $urandom_range(0, 1);
      spi_miso_drv = $urandom_range(0, 1); spi_mosi_drv = $urandom_range(0, 1);
      spi_sck_drv = $urandom_range(0, 1); spi_cs_drv = 4'($urandom);
      uart_te = $urandom_range(0, 1); uart_txd = $urandom_range(0, 1);
      cyc();
    end
    // R1: reset mid-run clears everything
    acc_addr = 1; spi_en = 0; uart_te = 0;
    do_reset();
    chk("R1 mid-run reset oe", pin_oe, 0);
    chk("R1 mid-run reset regs", acc_rdata, 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule